// File: doc/BRIEF.md
# Four-Channel Symmetric Window Multiplier

This block shapes four parallel sample streams with a Hamming window on their way into a streaming FFT. A frame counter follows the position of each valid sample inside a 4096-point frame and addresses one coefficient ROM that all four channels share. Each channel multiplies its sample by that coefficient in a pipelined multiplier and scales the product back to the sample width. The valid strobe and the frame-start marker travel alongside the data, so the FFT receives them aligned with the windowed samples.

The window is symmetric about the middle of the frame, so the ROM holds only the first half of it (2048 entries). In the second half the address is mirrored by inverting the low index bits. The ROM contents are computed inside the design when it is elaborated, from the window formula. No initialisation file is read.

Top module: `win_mult`

## Requirements
- R1: While `rst` (synchronous, active high) is asserted, `out_valid` and `out_sof` are 0 and `out_data` is all zeros, whatever the inputs do.
- R2: Every input cycle with `in_valid`=1 produces exactly one output cycle with `out_valid`=1, three clocks later. A new sample is accepted on every clock. `out_sof` leaves the block in the same cycle as the sample it was taken with.
- R3: For a frame index n in 0..2047, the coefficient is c(n) = round(511 * w(n) / w(2047)), where w(n) = 0.54 - 0.46*cos(2*pi*n/4095). This gives c(2047) = 511.
- R4: For a frame index n in 2048..4095, the coefficient is c(4095 - n). This equals the table entry whose address is the bitwise inverse of the low 11 index bits.
- R5: All four channels use the same coefficient for a given sample.
- R6: Each 16-bit lane of `out_data` equals floor(x * c / 512), saturated to the signed 16-bit range. Here x is the signed 16-bit lane of `in_data`, and lane k occupies bits [16k+15:16k].
- R7: A valid sample with `in_sof`=1 has frame index 0, and the sample after it has index 1.
- R8: Cycles with `in_valid`=0 do not advance the frame index.
- R9: Without a start marker, the index wraps from 4095 to 0, so the next sample uses c(0).
- R10: `in_sof` is ignored while `in_valid`=0. It neither restarts the index nor produces `out_sof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| in_sof | input | 1 | Marks the first sample of a frame (taken only with `in_valid`) |
| in_data | input | 64 | Four signed 16-bit samples, lane k at bits [16k+15:16k] |
| out_valid | output | 1 | Windowed sample strobe |
| out_sof | output | 1 | Frame start, aligned with `out_valid` |
| out_data | output | 64 | Four signed 16-bit windowed samples, same lane layout |

## Verification
The hard cases are the mirrored half of the table and the index wrap from 4095 to 0 without a marker. Both can only be reached after thousands of consecutive valid samples. The bench therefore streams one complete frame back to back, crossing the 2047/2048 mirror point on the way, and then keeps sending samples with no marker to force the wrap. It follows this with idle cycles that carry a stray start marker and a marker in the middle of a frame, checking each of them through the windowed output values.

// File: rtl/win_mult.sv
module win_mult #(
  parameter int CH        = 4,
  parameter int DATA_W    = 16,
  parameter int COEF_W    = 10,
  parameter int FRAME_LEN = 4096
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 in_sof,
  input  logic [CH*DATA_W-1:0] in_data,
  output logic                 out_valid,
  output logic                 out_sof,
  output logic [CH*DATA_W-1:0] out_data
);

  localparam int IDX_W  = $clog2(FRAME_LEN);
  localparam int HALF   = FRAME_LEN / 2;
  localparam int SHIFT  = COEF_W - 1;
  localparam int PROD_W = DATA_W + COEF_W + 1;
  localparam int FRAC   = 60;

  // Window numerator (0.54 - 0.46*cos) * 100, fixed point with FRAC bits
  function automatic logic signed [127:0] win_num(input int n);
    logic signed [127:0] pi_q, x, x2, term, sum;
    pi_q = 128'sh3243F6A8885A308D;
    x    = ((pi_q <<< 1) * 128'(n)) / 128'(FRAME_LEN - 1);
    x2   = (x * x) >>> FRAC;
    term = 128'sd1 <<< FRAC;
    sum  = term;
    for (int k = 1; k <= 28; k++) begin
      term = -(((term * x2) >>> FRAC) / 128'(2 * k * (2 * k - 1)));
      sum  = sum + term;
    end
    return (128'sd54 <<< FRAC) - 128'sd46 * sum;
  endfunction

  function automatic logic [COEF_W-1:0] coef_at(input int n);
    logic signed [127:0] num, den, q;
    num = win_num(n);
    den = win_num(HALF - 1);
    q   = (128'((2 ** COEF_W) - 2) * num + den) / (den <<< 1);
    return COEF_W'(q);
  endfunction

  logic [COEF_W-1:0] rom [HALF];

  for (genvar g = 0; g < HALF; g++) begin : g_rom
    localparam logic [COEF_W-1:0] CV = coef_at(g);
    assign rom[g] = CV;
  end

  logic [IDX_W-1:0] cnt;
  wire  [IDX_W-1:0] idx  = in_sof ? '0 : cnt;
  wire  [IDX_W-2:0] addr = idx[IDX_W-1] ? ~idx[IDX_W-2:0] : idx[IDX_W-2:0];

  always_ff @(posedge clk)
    if (rst)           cnt <= '0;
    else if (in_valid) cnt <= idx + IDX_W'(1);

  logic [COEF_W-1:0] coef_q;
  always_ff @(posedge clk) coef_q <= rom[addr];

  logic [2:0] v_q, s_q;
  always_ff @(posedge clk)
    if (rst) begin
      v_q <= '0;
      s_q <= '0;
    end else begin
      v_q <= {v_q[1:0], in_valid};
      s_q <= {s_q[1:0], in_valid & in_sof};
    end

  assign out_valid = v_q[2];
  assign out_sof   = s_q[2];

  localparam logic signed [PROD_W-1:0] YMAX = PROD_W'((2 ** (DATA_W - 1)) - 1);
  localparam logic signed [PROD_W-1:0] YMIN = ~YMAX;

  for (genvar c = 0; c < CH; c++) begin : g_ch
    logic signed [DATA_W-1:0] x_q;
    logic signed [PROD_W-1:0] p_q;
    logic signed [DATA_W-1:0] y_q;
    wire  signed [PROD_W-1:0] sh = p_q >>> SHIFT;

    always_ff @(posedge clk)
      if (rst) begin
        x_q <= '0;
        p_q <= '0;
        y_q <= '0;
      end else begin
        x_q <= in_data[c*DATA_W +: DATA_W];
        p_q <= PROD_W'(x_q) * PROD_W'($signed({1'b0, coef_q}));
        y_q <= (sh > YMAX) ? YMAX[DATA_W-1:0] :
               (sh < YMIN) ? YMIN[DATA_W-1:0] : sh[DATA_W-1:0];
      end

    assign out_data[c*DATA_W +: DATA_W] = y_q;
  end

endmodule

// File: rtl/win_mult_chk.sv
module win_mult_chk #(
  parameter int CH     = 4,
  parameter int DATA_W = 16,
  parameter int IDX_W  = 12
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic                 in_sof,
  input logic [CH*DATA_W-1:0] in_data,
  input logic                 out_valid,
  input logic                 out_sof,
  input logic [CH*DATA_W-1:0] out_data,
  input logic [IDX_W-1:0]     idx_cnt
);

  logic [1:0] warm;
  always_ff @(posedge clk)
    if (rst)              warm <= '0;
    else if (warm != 2'd3) warm <= warm + 2'd1;

  function automatic logic [DATA_W:0] mag(input logic [DATA_W-1:0] v);
    logic signed [DATA_W:0] e;
    e = {v[DATA_W-1], v};
    return (e < 0) ? -e : e;
  endfunction

  AST_VALID_DELAY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_valid == $past(in_valid, 3))); // R2
  AST_SOF_DELAY: assert property (@(posedge clk) disable iff (rst)
    (warm == 2'd3) |-> (out_sof == $past(in_valid && in_sof, 3))); // R10
  AST_SOF_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    out_sof |-> out_valid); // R2
  AST_IDX_RESTART: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_sof) |=> (idx_cnt == IDX_W'(1))); // R7
  AST_IDX_HOLD: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(idx_cnt)); // R8
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !in_sof && idx_cnt == '1) |=> (idx_cnt == '0)); // R9

  for (genvar c = 0; c < CH; c++) begin : g_gain
    AST_NO_GAIN: assert property (@(posedge clk) disable iff (rst)
      (warm == 2'd3) |-> (mag(out_data[c*DATA_W +: DATA_W]) <=
                          mag($past(in_data[c*DATA_W +: DATA_W], 3)))); // R6
  end

endmodule

bind win_mult win_mult_chk #(.CH(CH), .DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
  .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data), .idx_cnt(cnt)
);

// File: tb/tb_win_mult.sv
module tb_win_mult;

  localparam real PI = 3.14159265358979323846;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_sof = 1'b0;
  logic [63:0] in_data = '0;
  logic        out_valid, out_sof;
  logic [63:0] out_data;

  always #10 clk = ~clk;

  win_mult dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_sof(in_sof), .in_data(in_data),
    .out_valid(out_valid), .out_sof(out_sof), .out_data(out_data)
  );

  typedef struct {
    logic        sof;
    logic [63:0] data;
    int          cyc;
    string       tag;
  } item_t;

  item_t q[$];
  int total = 0;
  int bad = 0;
  int cyc = 0;
  int bidx = 0;
  int seed = 7;
  int coef_tab [2048];
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic int ref_coef(input int n);
    real w, wp;
    w  = 0.54 - 0.46 * $cos(2.0 * PI * n / 4095.0);
    wp = 0.54 - 0.46 * $cos(2.0 * PI * 2047.0 / 4095.0);
    return int'($floor(511.0 * w / wp + 0.5));
  endfunction

  function automatic logic [15:0] ref_mul(input logic [15:0] x, input int c);
    longint p;
    p = longint'($signed(x)) * c;
    p = p >>> 9;
    if (p > 32767)  p = 32767;
    if (p < -32768) p = -32768;
    return p[15:0];
  endfunction

  function automatic logic [15:0] lcg();
    seed = seed * 1103515245 + 12345;
    return seed[30:15];
  endfunction

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  task automatic push(input logic [63:0] d, input logic sof, input string tag);
    item_t it;
    int n, c;
    @(negedge clk);
    in_valid = 1'b1;
    in_sof   = sof;
    in_data  = d;
    n    = sof ? 0 : bidx;
    bidx = (n + 1) % 4096;
    c    = coef_tab[(n < 2048) ? n : 4095 - n];
    for (int k = 0; k < 4; k++) it.data[16*k +: 16] = ref_mul(d[16*k +: 16], c);
    it.sof = sof;
    it.cyc = cyc;
    it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(input int n, input logic sof);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = sof;
      in_data  = {lcg(), lcg(), lcg(), lcg()};
    end
    @(negedge clk);
    in_sof = 1'b0;
  endtask

  always @(negedge clk) begin
    if (mon_on && !done) begin
      if (out_valid) begin
        if (q.size() == 0) begin
          total++; bad++;
          $display("FAIL R2 unexpected output: actual out_valid=1 expected 0");
        end else begin
          item_t it;
          it = q.pop_front();
          total++;
          if (out_data !== it.data || out_sof !== it.sof) begin
            bad++;
            $display("FAIL %s data/sof: actual %h sof=%b expected %h sof=%b",
                     it.tag, out_data, out_sof, it.data, it.sof);
          end
          total++;
          if (cyc - it.cyc != 3) begin
            bad++;
            $display("FAIL R2 latency: actual %0d expected 3", cyc - it.cyc);
          end
        end
      end else if (q.size() != 0 && cyc - q[0].cyc > 3) begin
        total++; bad++;
        $display("FAIL R2 missing output: actual out_valid=0 expected 1");
        void'(q.pop_front());
      end
    end
  end

  always @(posedge clk) begin
    if (cyc > 30000 && !done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog: actual cycle %0d expected under 30000", cyc);
      summary();
    end
  end

  initial begin
    logic [63:0] d;
    for (int i = 0; i < 2048; i++) coef_tab[i] = ref_coef(i);

    // R1: inputs active during reset must not reach the outputs
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (i == 2);
      in_data  = {lcg(), lcg(), lcg(), lcg()};
    end
    total++;
    if (out_valid !== 1'b0 || out_sof !== 1'b0 || out_data !== 64'h0) begin
      bad++;
      $display("FAIL R1 reset outputs: actual v=%b s=%b d=%h expected 0 0 0",
               out_valid, out_sof, out_data);
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
    rst      = 1'b0;
    mon_on   = 1'b1;
    idle(3, 1'b0);

    // One full frame back to back: R3 lower half, R4 mirrored half
    for (int i = 0; i < 4096; i++) begin
      string tag;
      d   = {lcg(), lcg(), lcg(), lcg()};
      tag = (i < 2048) ? "R3" : "R4";
      if (i % 7 == 3) begin
        d[15:0] = 16'h7FFF; d[31:16] = 16'h8000; tag = "R6";
      end
      if (i % 11 == 5) begin
        d = {4{d[15:0]}}; tag = "R5";
      end
      push(d, i == 0, (i == 0) ? "R7" : tag);
    end

    // R9: continue past 4095 with no marker
    for (int i = 0; i < 5; i++) push({lcg(), lcg(), lcg(), lcg()}, 1'b0, "R9");

    // R10: marker on idle cycles is ignored
    idle(3, 1'b1);
    push({lcg(), lcg(), lcg(), lcg()}, 1'b0, "R10");

    // R8: gaps do not advance the index
    push({lcg(), lcg(), lcg(), lcg()}, 1'b0, "R8");
    idle(2, 1'b0);
    push({lcg(), lcg(), lcg(), lcg()}, 1'b0, "R8");
    idle(1, 1'b0);
    push({4{16'h8000}}, 1'b0, "R8");

    // R7: marker in the middle of a frame restarts the index
    push({lcg(), lcg(), lcg(), lcg()}, 1'b1, "R7");
    for (int i = 0; i < 4; i++) push({lcg(), lcg(), lcg(), lcg()}, 1'b0, "R7");
    idle(10, 1'b0);

    total++;
    if (q.size() != 0) begin
      bad++;
      $display("FAIL R2 pending outputs: actual %0d expected 0", q.size());
    end
    done = 1'b1;
    summary();
  end

endmodule